// File: doc/BRIEF.md
# ATM Cell Header Error Check and Correction Unit

This unit sits in the receive path of an ATM cell stream and inspects the five-byte header at the front of every 53-byte cell. It recomputes the header checksum over the first four header bytes, forms a syndrome against the fifth byte, and acts on it under one of four policies chosen by a 2-bit mode input. Depending on the policy, it repairs a header carrying a single flipped bit, flags the whole cell for discard, or both. It also keeps a running count of bad headers under rules that depend on the policy.

Bytes travel through a fixed five-stage delay line. The checksum byte is the last header byte, so the verdict on a header is ready when that byte arrives. The correction is then written back into the bytes already held in the line, so that every byte leaves the unit exactly five cycles after it entered. The discard verdict is a per-byte output flag that stays with every byte of the cell. The stream itself is not thinned, which leaves the actual removal to the consumer.

Top module: `hec_check_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `outValid`, `outSoc` and `outDrop` are 0 and `badCount` is 0.
- R2: Every byte accepted with `inValid` high leaves on `outData` exactly 5 clock cycles later, with the same start-of-cell marking. Bytes 6 to 53 of a cell are never altered. Idle cycles inside the payload are carried through as idle cycles.
- R3: The header checksum is a CRC-8 with generator x^8+x^2+x+1 and initial value 0. It is computed most significant bit first over header bytes 1 to 4, in arrival order, and the result is XORed with 0x55. A header whose fifth byte equals this value leaves unchanged, is not flagged for discard, and does not change the counter, in every mode.
- R4: Mode 0b00 passes through: the header is never altered, no cell is flagged for discard, and the counter never changes, whatever the checksum.
- R5: In mode 0b01, a header with exactly one flipped bit in any of its 40 bits leaves repaired. The cell is not flagged for discard and the counter is unchanged.
- R6: In mode 0b01, a header whose nonzero syndrome matches no single-bit pattern still passes unflagged. Header bytes 1 to 4 leave as received, byte 5 leaves recomputed from them, and the counter advances by one.
- R7: In mode 0b10, any checksum mismatch (including a single flipped bit) leaves the header unaltered, flags every byte of the cell for discard, and advances the counter by one.
- R8: In mode 0b11, a header with exactly one flipped bit leaves repaired, unflagged, and with the counter unchanged.
- R9: In mode 0b11, a header with an uncorrectable error flags every byte of the cell for discard, advances the counter by one, and leaves with byte 5 recomputed from bytes 1 to 4 as received.
- R10: `badCount` is `CNT_W` bits wide (16 by default). It holds at its all-ones value once reached, and moves by at most one per cell.
- R11: `outDrop` carries the same value on all 53 bytes of a cell. The value of `mode` is taken on the cycle the fifth header byte arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Header policy: 00 pass, 01 repair and keep, 10 discard on mismatch, 11 repair else discard |
| inValid | input | 1 | Input byte strobe |
| inSoc | input | 1 | Marks the first header byte of a cell |
| inData | input | 8 | Input byte |
| outValid | output | 1 | Output byte strobe |
| outSoc | output | 1 | Marks the first header byte of an output cell |
| outData | output | 8 | Output byte, header possibly repaired |
| outDrop | output | 1 | Cell flagged for discard, set on each of its bytes |
| badCount | output | CNT_W | Saturating count of bad headers |

## Verification
The assertions take for granted that the five header bytes of a cell arrive on five consecutive cycles, starting with the byte marked by `inSoc`. They also assume that a new cell starts only after the previous cell's 53 bytes have all entered. Gaps are allowed only in the payload and between cells. The stimulus follows this rule: it may insert random idle cycles after byte 5 and between cells, but never inside a header, and it holds `mode` steady for the whole cell. Headers are drawn at random and then given no error, one flipped bit at a chosen or random position, two flipped bits, or a random checksum byte. Directed runs cover all 40 bit positions in both repair modes and drive a narrowed counter into saturation.

// File: rtl/hec_pkg.sv
package hec_pkg;

  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 5;
  localparam int HDR_BITS  = BYTE_W * HDR_BYTES;
  localparam int CHK_BITS  = BYTE_W * (HDR_BYTES - 1);

  localparam logic [BYTE_W-1:0] GEN_POLY = 8'h07;
  localparam logic [BYTE_W-1:0] COSET    = 8'h55;

  typedef enum logic [1:0] {
    MODE_PASS     = 2'b00,
    MODE_FIX_KEEP = 2'b01,
    MODE_DROP     = 2'b10,
    MODE_FIX_DROP = 2'b11
  } hecMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic decide;    // fifth header byte present at the input this cycle
    logic applyFix;  // write repaired header and regenerated checksum
    logic dropCell;  // verdict for the cell being decided
  } hecStrobe_t;

  // CRC-8, MSB first, initial value zero
  function automatic logic [BYTE_W-1:0] crcOver(input logic [CHK_BITS-1:0] bits);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int i = CHK_BITS - 1; i >= 0; i--) begin
      if (r[BYTE_W-1] ^ bits[i]) r = {r[BYTE_W-2:0], 1'b0} ^ GEN_POLY;
      else                       r = {r[BYTE_W-2:0], 1'b0};
    end
    return r;
  endfunction

  // syndrome left by a lone flipped bit; pos 0 is the checksum LSB
  function automatic logic [BYTE_W-1:0] singleSyn(input int pos);
    logic [CHK_BITS-1:0] one;
    one = {{(CHK_BITS-1){1'b0}}, 1'b1};
    if (pos < BYTE_W) return {{(BYTE_W-1){1'b0}}, 1'b1} << pos;
    return crcOver(one << (pos - BYTE_W));
  endfunction

endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
  import hec_pkg::*;
(
  input  logic [HDR_BITS-1:0] rawHdr,
  output logic [BYTE_W-1:0]   syndrome,
  output logic                singleHit,
  output logic [HDR_BITS-1:0] flipMask
);

  assign syndrome = crcOver(rawHdr[HDR_BITS-1:BYTE_W]) ^ COSET ^ rawHdr[BYTE_W-1:0];

  for (genvar p = 0; p < HDR_BITS; p++) begin : g_pos
    localparam logic [BYTE_W-1:0] SIG = singleSyn(p);
    assign flipMask[p] = (syndrome == SIG);
  end

  assign singleHit = |flipMask;

  // R5: a syndrome points at no more than one bit
  always_comb begin
    assert_one_flip_R5: assert ($onehot0(flipMask))
      else $error("syndrome matched several single-bit patterns");
  end

endmodule

// File: rtl/hec_datapath.sv
module hec_datapath
  import hec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              inSoc,
  input  logic [BYTE_W-1:0] inData,
  input  hecStrobe_t        strobe,
  output logic              hdrBad,
  output logic              hdrSingle,
  output logic              outValid,
  output logic              outSoc,
  output logic [BYTE_W-1:0] outData,
  output logic              outDrop
);

  localparam int LAST = HDR_BYTES - 1;

  logic [BYTE_W-1:0] dat [HDR_BYTES];
  logic [LAST:0]     vld;
  logic [LAST:0]     sop;
  logic              dropReg;

  logic [HDR_BITS-1:0] rawHdr;
  logic [HDR_BITS-1:0] flipMask;
  logic [HDR_BITS-1:0] fixedHdr;
  logic [BYTE_W-1:0]   syndrome;
  logic [BYTE_W-1:0]   regenHec;
  logic [BYTE_W-1:0]   shiftIn [HDR_BYTES];

  // header byte j sits in stage LAST-1-j while its checksum is at the input
  for (genvar j = 0; j < HDR_BYTES - 1; j++) begin : g_raw
    assign rawHdr[HDR_BITS-1-j*BYTE_W -: BYTE_W] = dat[LAST-1-j];
  end
  assign rawHdr[BYTE_W-1:0] = inData;

  hec_syndrome u_syn (
    .rawHdr   (rawHdr),
    .syndrome (syndrome),
    .singleHit(hdrSingle),
    .flipMask (flipMask)
  );

  assign hdrBad   = |syndrome;
  assign fixedHdr = rawHdr ^ flipMask;
  assign regenHec = crcOver(fixedHdr[HDR_BITS-1:BYTE_W]) ^ COSET;

  assign shiftIn[0] = strobe.applyFix ? regenHec : inData;
  for (genvar k = 1; k < HDR_BYTES; k++) begin : g_shift
    assign shiftIn[k] = strobe.applyFix
                      ? fixedHdr[HDR_BITS-1-(LAST-k)*BYTE_W -: BYTE_W]
                      : dat[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HDR_BYTES; k++) dat[k] <= '0;
      vld     <= '0;
      sop     <= '0;
      dropReg <= 1'b0;
    end else begin
      for (int k = 0; k < HDR_BYTES; k++) dat[k] <= shiftIn[k];
      vld <= {vld[LAST-1:0], inValid};
      sop <= {sop[LAST-1:0], inValid & inSoc};
      if (strobe.decide) dropReg <= strobe.dropCell;
    end
  end

  assign outValid = vld[LAST];
  assign outSoc   = sop[LAST];
  assign outData  = dat[LAST];
  assign outDrop  = dropReg & vld[LAST];

  // R6, R9: after a rewrite the held header carries a consistent checksum
  assert_regen_hec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.applyFix |=> ((crcOver({dat[4], dat[3], dat[2], dat[1]}) ^ COSET) == dat[0]));

  // R2: without a rewrite the line only shifts
  assert_plain_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.applyFix |=> (dat[1] == $past(dat[0])));

endmodule

// File: rtl/hec_control.sv
module hec_control
  import hec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             inSoc,
  input  logic [1:0]       mode,
  input  logic             hdrBad,
  input  logic             hdrSingle,
  output hecStrobe_t       strobe,
  output logic [CNT_W-1:0] badCount
);

  localparam int               POS_W   = $clog2(HDR_BYTES + 1);
  localparam logic [POS_W-1:0] HEC_POS = POS_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [POS_W-1:0] pos;
  logic             inHdr;
  logic             hecNow;
  logic             bump;

  // pos is the index of the next header byte while inHdr is set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      inHdr <= 1'b0;
    end else if (inValid) begin
      if (inSoc) begin
        pos   <= POS_W'(1);
        inHdr <= 1'b1;
      end else if (inHdr) begin
        if (pos == HEC_POS) inHdr <= 1'b0;
        else                pos   <= pos + 1'b1;
      end
    end
  end

  assign hecNow = inValid && !inSoc && inHdr && (pos == HEC_POS);

  always_comb begin
    strobe        = '0;
    bump          = 1'b0;
    strobe.decide = hecNow;
    if (hecNow) begin
      unique case (hecMode_e'(mode))
        MODE_PASS: ;
        MODE_FIX_KEEP: begin
          strobe.applyFix = 1'b1;
          bump            = hdrBad && !hdrSingle;
        end
        MODE_DROP: begin
          strobe.dropCell = hdrBad;
          bump            = hdrBad;
        end
        MODE_FIX_DROP: begin
          strobe.applyFix = 1'b1;
          strobe.dropCell = hdrBad && !hdrSingle;
          bump            = hdrBad && !hdrSingle;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           badCount <= '0;
    else if (bump && badCount != CNT_MAX) badCount <= badCount + 1'b1;
  end

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (badCount == $past(badCount)) || (badCount == $past(badCount) + 1'b1));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (badCount == CNT_MAX) |=> (badCount == CNT_MAX));

  assert_pass_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hecNow && mode == MODE_PASS) |=> $stable(badCount));

  assert_repair_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hecNow && hdrSingle && mode[0]) |=> $stable(badCount));

endmodule

// File: rtl/hec_check_unit.sv
module hec_check_unit
  import hec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             inValid,
  input  logic             inSoc,
  input  logic [7:0]       inData,
  output logic             outValid,
  output logic             outSoc,
  output logic [7:0]       outData,
  output logic             outDrop,
  output logic [CNT_W-1:0] badCount
);

  hecStrobe_t strobe;
  logic       hdrBad;
  logic       hdrSingle;

  hec_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inSoc    (inSoc),
    .mode     (mode),
    .hdrBad   (hdrBad),
    .hdrSingle(hdrSingle),
    .strobe   (strobe),
    .badCount (badCount)
  );

  hec_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inSoc    (inSoc),
    .inData   (inData),
    .strobe   (strobe),
    .hdrBad   (hdrBad),
    .hdrSingle(hdrSingle),
    .outValid (outValid),
    .outSoc   (outSoc),
    .outData  (outData),
    .outDrop  (outDrop)
  );

  // R11: the discard flag never rises in the middle of a cell
  assert_drop_at_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outSoc && $past(outValid)) |-> (outDrop == $past(outDrop)));

endmodule

// File: tb/hec_check_unit_test.sv
module hec_check_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 4;
  localparam int CELL_BYTES = 53;
  localparam int LAT        = 5;
  localparam int WATCHDOG   = 150000;
  localparam logic [TB_CNT_W-1:0] TB_MAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic inValid = 1'b0;
  logic inSoc = 1'b0;
  logic [7:0] inData = 8'h00;
  logic outValid, outSoc, outDrop;
  logic [7:0] outData;
  logic [TB_CNT_W-1:0] badCount;

  hec_check_unit #(.CNT_W(TB_CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .inValid(inValid), .inSoc(inSoc),
    .inData(inData), .outValid(outValid), .outSoc(outSoc), .outData(outData),
    .outDrop(outDrop), .badCount(badCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  int expCount = 0;

  typedef struct packed {
    int         stamp;
    logic       soc;
    logic [7:0] data;
    logic       drop;
  } expByte_t;

  expByte_t expQ[$];
  string    reqQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [31:0] d);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 31; i >= 0; i--)
      r = (r[7] ^ d[i]) ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  function automatic logic [7:0] synOf(input logic [39:0] h);
    return crc8(h[39:8]) ^ 8'h55 ^ h[7:0];
  endfunction

  function automatic logic [39:0] goodHdr(input logic [31:0] body);
    return {body, crc8(body) ^ 8'h55};
  endfunction

  // output monitor: every byte, its timing, marker and verdict
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected output byte", outData, 0);
      end else begin
        expByte_t e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(cyc == e.stamp, "R2", "output cycle", cyc, e.stamp);
        check(outSoc == e.soc, "R2", "start marker", outSoc, e.soc);
        check(outData == e.data, r, "byte value", outData, e.data);
        check(outDrop == e.drop, (r == "R2") ? "R11" : r, "discard flag", outDrop, e.drop);
      end
    end
  end

  task automatic sendCell(input logic [1:0] m, input logic [39:0] rx, input string req);
    logic [7:0]  s;
    logic [39:0] fx;
    logic [39:0] outH;
    logic        drop;
    bit          bump;
    int          hit;
    logic [7:0]  b;
    hit = -1;
    s = synOf(rx);
    for (int p = 0; p < 40; p++) begin
      logic [39:0] one;
      one = 40'd1 << p;
      if (s != 8'h00 && synOf(goodHdr(32'h0) ^ one) == s) hit = p;
    end
    fx = rx;
    if (hit >= 0) fx[hit] = ~fx[hit];
    outH = rx; drop = 1'b0; bump = 1'b0;
    case (m)
      2'b01: begin
        outH = {fx[39:8], crc8(fx[39:8]) ^ 8'h55};
        bump = (s != 0) && (hit < 0);
      end
      2'b10: begin
        drop = (s != 0);
        bump = (s != 0);
      end
      2'b11: begin
        outH = {fx[39:8], crc8(fx[39:8]) ^ 8'h55};
        drop = (s != 0) && (hit < 0);
        bump = drop;
      end
      default: ;
    endcase
    if (bump && expCount < int'(TB_MAX)) expCount++;
    for (int i = 0; i < CELL_BYTES; i++) begin
      if (i >= 5 && $urandom_range(0, 3) == 0) begin
        @(negedge clk);
        inValid = 1'b0;
        inSoc   = 1'b0;
      end
      b = (i < 5) ? outH[39-8*i -: 8] : 8'($urandom);
      @(negedge clk);
      mode    = m;
      inValid = 1'b1;
      inSoc   = (i == 0);
      inData  = (i < 5) ? rx[39-8*i -: 8] : b;
      expQ.push_back('{stamp: cyc + LAT, soc: (i == 0), data: b, drop: drop});
      reqQ.push_back((i < 5) ? req : "R2");
    end
    @(negedge clk);
    inValid = 1'b0;
    inSoc   = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
    check(badCount == TB_CNT_W'(expCount),
          (req == "R2") ? "R10" : req, "bad header count", badCount, expCount);
  endtask

  function automatic logic [39:0] twoFlips(input logic [39:0] h);
    int a;
    int c;
    a = $urandom_range(0, 39);
    c = (a + 1 + $urandom_range(0, 38)) % 40;
    return h ^ (40'd1 << a) ^ (40'd1 << c);
  endfunction

  task automatic doReset();
    repeat (LAT + 2) @(negedge clk);
    rst_n = 1'b0;
    expCount = 0;
    @(negedge clk);
    check(!outValid && !outDrop && !outSoc, "R1", "outputs in reset",
          {outValid, outSoc, outDrop}, 0);
    check(badCount == 0, "R1", "count in reset", badCount, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!outValid && !outDrop && badCount == 0, "R1", "outputs after reset",
          {outValid, outDrop, badCount}, 0);
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] h;
    int unsigned seedv;
    seedv = $urandom(32'h5eed);
    doReset();

    // R3: clean headers in every mode
    for (int m = 0; m < 4; m++) sendCell(2'(m), goodHdr($urandom), "R3");
    // R4: errors ignored in pass mode
    sendCell(2'b00, twoFlips(goodHdr($urandom)), "R4");
    sendCell(2'b00, goodHdr($urandom) ^ 40'h80_0000_0000, "R4");
    // R5, R8: every single bit position
    for (int p = 0; p < 40; p++) begin
      sendCell(2'b01, goodHdr($urandom) ^ (40'd1 << p), "R5");
      sendCell(2'b11, goodHdr($urandom) ^ (40'd1 << p), "R8");
    end
    // R6, R7, R9: uncorrectable and mismatch cases
    sendCell(2'b01, twoFlips(goodHdr($urandom)), "R6");
    sendCell(2'b10, goodHdr($urandom) ^ 40'h00_0000_0100, "R7");
    sendCell(2'b10, twoFlips(goodHdr($urandom)), "R7");
    sendCell(2'b11, twoFlips(goodHdr($urandom)), "R9");
    sendCell(2'b01, goodHdr($urandom) ^ 40'h00_0000_0000 ^ {32'h0, 8'h5a}, "R6");

    // random mix
    doReset();
    for (int n = 0; n < 120; n++) begin
      h = goodHdr($urandom);
      case ($urandom_range(0, 3))
        0: ;
        1: h = h ^ (40'd1 << $urandom_range(0, 39));
        2: h = twoFlips(h);
        default: h[7:0] = 8'($urandom);
      endcase
      sendCell(2'($urandom_range(0, 3)), h, "R2");
    end

    // R10: saturation of a narrow counter
    doReset();
    for (int n = 0; n < 20; n++) sendCell(2'b10, twoFlips(goodHdr($urandom)), "R10");
    check(badCount == TB_MAX, "R10", "saturated count", badCount, TB_MAX);
    sendCell(2'b11, twoFlips(goodHdr($urandom)), "R10");

    repeat (LAT + 3) @(negedge clk);
    check(expQ.size() == 0, "R2", "bytes still expected", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule